// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus that a target device has left hung with its data line held low, typically after a controller reset in the middle of a read. It controls both wires in open-drain style: for each line it asserts a pull-low enable and never drives high, and it reads back the real level of each line through a two-flop synchronizer.

When the recover command arrives, both lines start out released. While the data line reads low, the block clocks the bus one pulse at a time. Before each pulse it waits for the clock line to read high, so a target that stretches the clock is honoured. It then waits one interval, pulls the clock low for one interval and releases it for one interval. As soon as data reads high, it issues a START and then a STOP, so every target sees a clean framing state.

All timing comes from a parameter that gives the system clock cycles per interval. A pulse budget and a clock-stretch limit bound the run. The outcome is reported as a sticky done flag or a sticky error flag, and a busy level covers the whole sequence.

Top module: `i2c_unhang`

## Requirements
- R1: After reset, scl_pull_o, sda_pull_o, busy_o, done_o and err_o are all 0, where a pull output of 1 means that line is driven low.
- R2: A recover_i high while idle starts a run. busy_o is 1 from the next cycle until the run ends, and done_o and err_o read 0 during the run.
- R3: While the synchronized data line reads low, each clock pulse takes 2 + 3*TICKS_PER_STEP cycles: one decision cycle, one cycle to see the clock line high, then one interval released, one interval with scl_pull_o high, and one interval released.
- R4: Before each pulse the block waits for as long as the clock line is held low by another device, and the pulse is delayed by exactly that many cycles.
- R5: Once data reads high, sda_pull_o rises while the clock line is high (START). One interval later scl_pull_o rises. One interval after that scl_pull_o falls, and one interval later sda_pull_o falls (STOP) and done_o is set. On a free bus the run lasts 1 + 3*TICKS_PER_STEP cycles.
- R6: If data still reads low after MAX_PULSES pulses, the run ends one cycle later with err_o set and both lines released. If data reads high after exactly MAX_PULSES pulses, the run still succeeds.
- R7: If the clock line reads low for STRETCH_LIMIT consecutive cycles while the block waits before a pulse, the run ends with err_o set and both lines released.
- R8: Both line inputs pass through two flops before any decision, so a change on a line is acted upon two cycles after it occurs.
- R9: recover_i is ignored while busy_o is 1, and the run's length and output are unchanged.
- R10: done_o and err_o are never 1 together. Each holds its value until the next recover command clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_i | input | 1 | Start a recovery run (acted on only when idle) |
| scl_i | input | 1 | Sampled level of the clock line |
| sda_i | input | 1 | Sampled level of the data line |
| scl_pull_o | output | 1 | 1 = drive clock line low, 0 = release |
| sda_pull_o | output | 1 | 1 = drive data line low, 0 = release |
| busy_o | output | 1 | A recovery run is in progress |
| done_o | output | 1 | Last run ended with a clean bus (sticky) |
| err_o | output | 1 | Last run aborted: pulse budget or stretch limit (sticky) |

## Verification
Every result of a run is due at a cycle that can be computed in advance, counting from the edge that takes the command. That cycle is K*(2+3T) + 1 + 3T for success after K pulses, MAX_PULSES*(2+3T) + 1 for an exhausted pulse budget, and STRETCH_LIMIT + 1 for a stuck clock line, plus S cycles when the clock is stretched for S cycles after the command. The driver works out these values from the requirements and queues them. The monitor samples on falling edges, counts the cycles busy_o is high and the pull-low events, and detects START and STOP on the modelled wired lines. It compares everything at the falling edge where busy_o is first seen low, which is the same edge at which the final STOP appears on the line.

// File: rtl/i2c_unhang_pkg.sv
package i2c_unhang_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_WAIT_HI,
    ST_PRE,
    ST_LOW,
    ST_HIGH,
    ST_STA_SDA,
    ST_STA_SCL,
    ST_STO_SCL
  } rec_state_e;
endpackage

// File: rtl/i2c_unhang_sync.sv
module i2c_unhang_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  // idle bus lines are high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/i2c_unhang_cnt.sv
module i2c_unhang_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;

  always_comb begin
    hit   = run_i && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run_i || hit) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = hit;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/i2c_unhang_fsm.sv
module i2c_unhang_fsm
  import i2c_unhang_pkg::*;
#(
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic tick_i,
  input  logic stall_hit_i,
  output logic timed_o,
  output logic stall_run_o,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PULSES);

  rec_state_e    state_q, state_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          done_q, done_d, err_q, err_d;
  logic          scl_pull_q, scl_pull_d, sda_pull_q, sda_pull_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    pulse_d = pulse_q;
    done_d  = done_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_DECIDE;
        pulse_d = '0;
        done_d  = 1'b0;
        err_d   = 1'b0;
      end
      ST_DECIDE: begin
        if (sda_s_i)              state_d = ST_STA_SDA;
        else if (pulse_q == PMAX) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else                  state_d = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        if (scl_s_i)          state_d = ST_PRE;
        else if (stall_hit_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_PRE:  if (tick_i) state_d = ST_LOW;
      ST_LOW:  if (tick_i) state_d = ST_HIGH;
      ST_HIGH: if (tick_i) begin
        state_d = ST_DECIDE;
        pulse_d = pulse_q + 1'b1;
      end
      ST_STA_SDA: if (tick_i) state_d = ST_STA_SCL;
      ST_STA_SCL: if (tick_i) state_d = ST_STO_SCL;
      ST_STO_SCL: if (tick_i) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // line drive decoded from the next state, registered for clean edges
  always_comb begin
    scl_pull_d = (state_d == ST_LOW) || (state_d == ST_STA_SCL);
    sda_pull_d = (state_d == ST_STA_SDA) || (state_d == ST_STA_SCL) ||
                 (state_d == ST_STO_SCL);
  end

  always_comb begin
    timed_o = (state_q == ST_PRE) || (state_q == ST_LOW) || (state_q == ST_HIGH) ||
              (state_q == ST_STA_SDA) || (state_q == ST_STA_SCL) ||
              (state_q == ST_STO_SCL);
    stall_run_o = (state_q == ST_WAIT_HI) && !scl_s_i;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pulse_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      scl_pull_q <= 1'b0;
      sda_pull_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pulse_q    <= pulse_d;
      done_q     <= done_d;
      err_q      <= err_d;
      scl_pull_q <= scl_pull_d;
      sda_pull_q <= sda_pull_d;
    end
  end

  assign scl_pull_o = scl_pull_q;
  assign sda_pull_o = sda_pull_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_pull_o && !sda_pull_o));

  // R3
  pull_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> $past(tick_i));

  // R5
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> (!busy_o && done_o));

  // R6
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PMAX);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($past(stall_hit_i) || ($past(pulse_q) == PMAX)));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
endmodule

// File: rtl/i2c_unhang.sv
module i2c_unhang #(
  parameter int TICKS_PER_STEP = 1000,
  parameter int MAX_PULSES     = 9,
  parameter int STRETCH_LIMIT  = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  logic [1:0] lines_s;
  logic       timed, tick, stall_run, stall_hit;

  i2c_unhang_sync #(.W(2)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({scl_i, sda_i}),
    .q_o  (lines_s)
  );

  i2c_unhang_cnt #(.LIMIT(TICKS_PER_STEP)) step_cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run_i(timed),
    .hit_o(tick)
  );

  i2c_unhang_cnt #(.LIMIT(STRETCH_LIMIT)) stall_cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run_i(stall_run),
    .hit_o(stall_hit)
  );

  i2c_unhang_fsm #(.MAX_PULSES(MAX_PULSES)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (recover_i),
    .scl_s_i    (lines_s[1]),
    .sda_s_i    (lines_s[0]),
    .tick_i     (tick),
    .stall_hit_i(stall_hit),
    .timed_o    (timed),
    .stall_run_o(stall_run),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );
endmodule

// File: tb/i2c_unhang_tb_top.sv
module i2c_unhang_tb_top;
  localparam int T    = 4;
  localparam int MAXP = 9;
  localparam int LIM  = 50;
  localparam int PER  = 2 + 3 * T;

  typedef struct {
    int done;
    int err;
    int dur;
    int pulses;
    int starts;
    int stops;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, recover;
  logic scl_pull, sda_pull, busy, done, err;
  logic hold_scl;
  int   stuck_k;
  int   fall_cnt;
  logic scl_line, sda_line;

  int errors = 0;
  int checks = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  // wired-AND bus: device pull, bench target hold
  assign scl_line = !scl_pull && !hold_scl;
  assign sda_line = !sda_pull && !(fall_cnt < stuck_k);

  i2c_unhang #(.TICKS_PER_STEP(T), .MAX_PULSES(MAXP), .STRETCH_LIMIT(LIM)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .recover_i (recover),
    .scl_i     (scl_line),
    .sda_i     (sda_line),
    .scl_pull_o(scl_pull),
    .sda_pull_o(sda_pull),
    .busy_o    (busy),
    .done_o    (done),
    .err_o     (err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // target model: holds SDA low until it has seen stuck_k SCL falls in a run
  logic t_prev_scl = 1'b1;
  always @(negedge clk) begin
    if (!busy) fall_cnt <= 0;
    else if (t_prev_scl && !scl_line) fall_cnt <= fall_cnt + 1;
    t_prev_scl <= scl_line;
  end

  // monitor / scoreboard
  logic p_scl = 1'b1, p_sda = 1'b1, p_busy = 1'b0, p_pull = 1'b0;
  int m_dur = 0, m_pulses = 0, m_starts = 0, m_stops = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) m_dur++;
      if (scl_pull && !p_pull) m_pulses++;
      if (busy || p_busy) begin
        if (p_scl && scl_line && p_sda && !sda_line) m_starts++;
        if (p_scl && scl_line && !p_sda && sda_line) m_stops++;
      end
      if (p_busy && !busy) begin
        if (exp_q.size() == 0) begin
          check("R2", "unexpected run end", 1, 0);
        end else begin
          exp_t  e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(tg, "done", int'(done), e.done);
          check(tg, "err", int'(err), e.err);
          check(tg, "duration", m_dur, e.dur);
          check(tg, "scl pulls", m_pulses, e.pulses);
          check(tg, "start count", m_starts, e.starts);
          check(tg, "stop count", m_stops, e.stops);
          check(tg, "lines released", int'(scl_pull || sda_pull), 0);
        end
        m_dur = 0; m_pulses = 0; m_starts = 0; m_stops = 0;
      end
    end
    p_scl  = scl_line;
    p_sda  = sda_line;
    p_busy = busy;
    p_pull = scl_pull;
  end

  int last_done = 0, last_err = 0;

  // k: pulses before SDA frees (>MAXP = never); s: stretch cycles; hang: SCL held forever
  task automatic run_case(input int k, input int s, input bit hang, input bit poke, input string tag);
    exp_t e;
    e.starts = 0; e.stops = 0; e.done = 0; e.err = 0;
    if (hang) begin
      e.err = 1; e.dur = LIM + 1; e.pulses = 0;
    end else if (k > MAXP) begin
      e.err = 1; e.dur = MAXP * PER + 1; e.pulses = MAXP;
    end else begin
      e.done = 1; e.dur = k * PER + 1 + 3 * T + s; e.pulses = k + 1;
      e.starts = 1; e.stops = 1;
    end
    @(negedge clk);
    stuck_k  = (k > MAXP) ? 1000 : k;
    hold_scl = hang || (s > 0);
    repeat (4) @(negedge clk);
    // R10: flags still hold the previous outcome
    check("R10", "held done", int'(done), last_done);
    check("R10", "held err", int'(err), last_err);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    recover = 1'b1;
    @(negedge clk);
    recover = 1'b0;
    check("R2", "busy after command", int'(busy), 1);
    check("R10", "flags cleared", int'(done || err), 0);
    if (s > 0) begin
      repeat (s - 1) @(negedge clk);
      hold_scl = 1'b0;
    end
    if (poke) begin
      repeat (6) @(negedge clk);
      recover = 1'b1;
      @(negedge clk);
      recover = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    hold_scl  = 1'b0;
    last_done = e.done;
    last_err  = e.err;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; recover = 1'b0; hold_scl = 1'b0; stuck_k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "err", int'(err), 0);
    check("R1", "pulls", int'(scl_pull || sda_pull), 0);
    run_case(0, 0, 1'b0, 1'b0, "R5");       // free bus: START/STOP only
    run_case(3, 0, 1'b0, 1'b0, "R3");       // three pulses
    run_case(MAXP + 1, 0, 1'b0, 1'b0, "R6"); // never frees: budget exhausted
    run_case(MAXP, 0, 1'b0, 1'b0, "R6");    // frees on the last allowed pulse
    run_case(1, 10, 1'b0, 1'b0, "R4 R8");   // stretched clock, two-flop delay
    run_case(2, 0, 1'b1, 1'b0, "R7");       // clock held low forever
    run_case(2, 0, 1'b0, 1'b1, "R9");       // command repeated mid-run
    run_case(0, 0, 1'b0, 1'b0, "R10");      // clean run after an error
    check("R2", "runs left unreported", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule